// File: doc/BRIEF.md
# Slave-Controllable Up-Counting Timer

This block is a general-purpose up-counter. A prescaler divides the clock, and a period register sets the wrap point. A small slave controller decides when the counter may advance. Software reaches it through a single-cycle register write port and a combinational read port. The current count and a one-cycle update pulse are exported for neighbouring logic.

The period can be written through at once or held in a shadow copy that only takes effect at the next update event. The prescaler value is always held in a shadow copy. A software-forced update restarts both the count and the prescaler and loads both shadows.

The slave controller is a state machine with six states:
- ST_OFF: stopped, no trigger armed.
- ST_ARMED: stopped, and waiting for a rising trigger edge.
- ST_FREE: counting on every prescaler tick.
- ST_GATED: counting only while the selected trigger is high.
- ST_TRIGGERED: counting, after a trigger edge set the run bit.
- ST_QUAD: counting up or down from two phase inputs.

Every transition goes to the state that encodes the next run bit and the next mode code:
- A write to the control register sets the next run bit.
- A mode write sets the next mode code.
- A rising trigger edge seen in ST_ARMED moves the block to ST_TRIGGERED.
- Mode codes other than 3, 5 and 6 select ST_FREE when the run bit is set.

Trigger inputs and phase inputs pass through two synchroniser flops before they are used.

Top module: `slv_timer`

Register map, with the address on `wr_addr`/`rd_addr`:

| Address | Name | Fields |
|---|---|---|
| 0 | CTRL | bit 0 = run, bit 1 = period preload enable |
| 1 | MODE | bits [2:0] = mode code, bits [5:4] = trigger index |
| 2 | EVT | bit 0 = force update, reads 0 |
| 3 | PRESC | prescaler value |
| 4 | PERIOD | period value, resets to all ones |
| 5 | COUNT | counter value |

## Requirements
- R1: After reset the count is 0, no update pulse is issued, CTRL reads 0, MODE reads 0 and PERIOD (address 4) reads all ones.
- R2: In free-running mode (mode code 0) with run set, the count advances once every PRESC+1 clocks and goes back to 0 after reaching PERIOD. The update rate is therefore clk/((PRESC+1)*(PERIOD+1)).
- R3: `upd_o` is high for exactly one cycle for each wrap, appearing together with the wrapped count.
- R4: With preload set (CTRL bit 1), a PERIOD write takes effect only after the next update event, and the count runs on to the old period.
- R5: With preload clear, a PERIOD write takes effect at once. If the count already equals or exceeds the new period, the next tick wraps it to 0 with an update.
- R6: Writing 1 to EVT bit 0 clears the count and the prescaler, loads both shadows and pulses `upd_o` in the next cycle. EVT reads back as 0.
- R7: Clearing the run bit freezes the count at its present value.
- R8: A COUNT write sets the count on the next clock.
- R9: In gated mode (code 5), ticks are counted only during clocks in which the synchronised selected trigger is high.
- R10: In triggered mode (code 6) with run clear, a rising edge on the selected trigger sets the run bit in hardware. Counting begins three clocks after the input rises and continues after the trigger falls, until software clears run.
- R11: Trigger inputs other than the one chosen by MODE bits [5:4] neither gate nor start the counter.
- R12: In quadrature mode (code 3), each edge of either phase input changes the count by one. The count goes up when `enc_a_i` leads `enc_b_i` and down otherwise, so a full input cycle gives four counts.
- R13: In quadrature mode, counting up past PERIOD wraps to 0 and counting down below 0 wraps to PERIOD, each with an update pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Register read data, combinational |
| trig_i | input | NUM_TRIG | External trigger inputs, asynchronous |
| enc_a_i | input | 1 | Quadrature phase A, asynchronous |
| enc_b_i | input | 1 | Quadrature phase B, asynchronous |
| cnt_o | output | CNT_W | Current count |
| upd_o | output | 1 | Update event pulse |

## Verification
The bench builds the timer with an 8-bit counter and a 4-bit prescaler. With these widths the largest period wraps after 256 ticks and the largest prescale divides by 16. Full wraps, multi-wrap update counts and the down-wrap to PERIOD therefore fit in a few hundred clocks. Four trigger inputs are kept, so the selected input can be checked against its unselected neighbours.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ARMED,
        ST_FREE,
        ST_GATED,
        ST_TRIGGERED,
        ST_QUAD
    } slv_state_e;

    localparam logic [2:0] MODE_FREE  = 3'd0;
    localparam logic [2:0] MODE_QUAD  = 3'd3;
    localparam logic [2:0] MODE_GATED = 3'd5;
    localparam logic [2:0] MODE_TRIG  = 3'd6;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_MODE   = 3'd1;
    localparam logic [2:0] A_EVT    = 3'd2;
    localparam logic [2:0] A_PRESC  = 3'd3;
    localparam logic [2:0] A_PERIOD = 3'd4;
    localparam logic [2:0] A_COUNT  = 3'd5;

endpackage

// File: rtl/tmr_trig_sel.sv
module tmr_trig_sel #(
    parameter int NUM_TRIG = 4,
    parameter int SEL_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] trig_i,
    input  logic [SEL_W-1:0]    sel_i,
    output logic                level_o,
    output logic                rise_o
);
    logic [NUM_TRIG-1:0] meta_q;
    logic [NUM_TRIG-1:0] sync_q;
    logic                prev_q;

    genvar g;
    generate
        for (g = 0; g < NUM_TRIG; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q[g] <= 1'b0;
                    sync_q[g] <= 1'b0;
                end else begin
                    meta_q[g] <= trig_i[g];
                    sync_q[g] <= meta_q[g];
                end
            end
        end
    endgenerate

    always_comb begin
        level_o = 1'b0;
        for (int i = 0; i < NUM_TRIG; i++)
            if (sel_i == SEL_W'(i)) level_o = sync_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_o;
    end

    assign rise_o = level_o & ~prev_q;

endmodule

// File: rtl/tmr_quad.sv
module tmr_quad (
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    input  logic b_i,
    output logic step_o,
    output logic up_o
);
    logic [1:0] a_sync_q, b_sync_q;
    logic       a_prev_q, b_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_sync_q <= 2'b00;
            b_sync_q <= 2'b00;
            a_prev_q <= 1'b0;
            b_prev_q <= 1'b0;
        end else begin
            a_sync_q <= {a_sync_q[0], a_i};
            b_sync_q <= {b_sync_q[0], b_i};
            a_prev_q <= a_sync_q[1];
            b_prev_q <= b_sync_q[1];
        end
    end

    // exactly one phase moved: a valid quadrature step
    assign step_o = (a_sync_q[1] ^ a_prev_q) ^ (b_sync_q[1] ^ b_prev_q);
    assign up_o   = a_sync_q[1] ^ b_prev_q;

endmodule

// File: rtl/tmr_slave_fsm.sv
module tmr_slave_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr_i,
    input  logic       run_wr_i,
    input  logic [2:0] mode_i,
    input  logic       trig_lvl_i,
    input  logic       trig_rise_i,
    output logic       run_o,
    output logic       psc_en_o,
    output logic       quad_en_o
);
    slv_state_e state_q, state_d;
    logic       cur_run, next_run;

    function automatic slv_state_e encode(input logic run, input logic [2:0] m);
        if (!run)            return (m == MODE_TRIG) ? ST_ARMED : ST_OFF;
        if (m == MODE_GATED) return ST_GATED;
        if (m == MODE_TRIG)  return ST_TRIGGERED;
        if (m == MODE_QUAD)  return ST_QUAD;
        return ST_FREE;
    endfunction

    assign cur_run = (state_q != ST_OFF) && (state_q != ST_ARMED);

    always_comb begin
        if (ctrl_wr_i)
            next_run = run_wr_i;
        else if (state_q == ST_ARMED && trig_rise_i)
            next_run = 1'b1;
        else
            next_run = cur_run;
        state_d = encode(next_run, mode_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        run_o     = 1'b0;
        psc_en_o  = 1'b0;
        quad_en_o = 1'b0;
        unique case (state_q)
            ST_OFF, ST_ARMED: ;
            ST_FREE, ST_TRIGGERED: begin
                run_o    = 1'b1;
                psc_en_o = 1'b1;
            end
            ST_GATED: begin
                run_o    = 1'b1;
                psc_en_o = trig_lvl_i;
            end
            ST_QUAD: begin
                run_o     = 1'b1;
                quad_en_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R10
    trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && trig_rise_i && !ctrl_wr_i) |=> run_o);

endmodule

// File: rtl/slv_timer.sv
module slv_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 16,
    parameter int PSC_W    = 16,
    parameter int NUM_TRIG = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [2:0]          rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [NUM_TRIG-1:0] trig_i,
    input  logic                enc_a_i,
    input  logic                enc_b_i,
    output logic [CNT_W-1:0]    cnt_o,
    output logic                upd_o
);
    localparam int SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

    logic             preload_q;
    logic [2:0]       mode_q, mode_d;
    logic [SEL_W-1:0] sel_q;
    logic [PSC_W-1:0] psc_reg_q, psc_sh_q, psc_cnt_q;
    logic [CNT_W-1:0] arr_reg_q, arr_sh_q, arr_eff, cnt_q;
    logic             upd_q;

    logic ctrl_wr, mode_wr, ug_wr, cnt_wr;
    logic trig_lvl, trig_rise, q_step, q_up;
    logic run_w, psc_en, quad_en;
    logic tick, wrap, upd_d;

    assign ctrl_wr = wr_en && wr_addr == A_CTRL;
    assign mode_wr = wr_en && wr_addr == A_MODE;
    assign ug_wr   = wr_en && wr_addr == A_EVT && wr_data[0];
    assign cnt_wr  = wr_en && wr_addr == A_COUNT;
    assign mode_d  = mode_wr ? wr_data[2:0] : mode_q;

    tmr_trig_sel #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .sel_i(sel_q),
        .level_o(trig_lvl), .rise_o(trig_rise));

    tmr_quad u_quad (
        .clk(clk), .rst_n(rst_n), .a_i(enc_a_i), .b_i(enc_b_i),
        .step_o(q_step), .up_o(q_up));

    tmr_slave_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr), .run_wr_i(wr_data[0]),
        .mode_i(mode_d), .trig_lvl_i(trig_lvl), .trig_rise_i(trig_rise),
        .run_o(run_w), .psc_en_o(psc_en), .quad_en_o(quad_en));

    assign arr_eff = preload_q ? arr_sh_q : arr_reg_q;
    assign tick    = psc_en && (psc_cnt_q >= psc_sh_q);

    always_comb begin
        wrap = 1'b0;
        if (quad_en && q_step)
            wrap = q_up ? (cnt_q >= arr_eff) : (cnt_q == '0);
        else if (tick)
            wrap = (cnt_q >= arr_eff);
        upd_d = ug_wr || (wrap && !cnt_wr);
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preload_q <= 1'b0;
            mode_q    <= MODE_FREE;
            sel_q     <= '0;
            psc_reg_q <= '0;
            arr_reg_q <= '1;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL:   preload_q <= wr_data[1];
                A_MODE: begin
                    mode_q <= wr_data[2:0];
                    sel_q  <= wr_data[4 +: SEL_W];
                end
                A_PRESC:  psc_reg_q <= wr_data[PSC_W-1:0];
                A_PERIOD: arr_reg_q <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // shadows and prescaler
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_sh_q  <= '0;
            arr_sh_q  <= '1;
            psc_cnt_q <= '0;
        end else begin
            if (upd_d) begin
                psc_sh_q <= psc_reg_q;
                arr_sh_q <= arr_reg_q;
            end
            if (ug_wr || tick)
                psc_cnt_q <= '0;
            else if (psc_en)
                psc_cnt_q <= psc_cnt_q + 1'b1;
        end
    end

    // main counter and update pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            upd_q <= 1'b0;
        end else begin
            upd_q <= upd_d;
            if (ug_wr)
                cnt_q <= '0;
            else if (cnt_wr)
                cnt_q <= wr_data[CNT_W-1:0];
            else if (quad_en && q_step) begin
                if (q_up) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
                else      cnt_q <= wrap ? arr_eff : cnt_q - 1'b1;
            end else if (tick)
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:   rd_data = DATA_W'({preload_q, run_w});
            A_MODE:   rd_data = DATA_W'({sel_q, 1'b0, mode_q});
            A_PRESC:  rd_data = DATA_W'(psc_reg_q);
            A_PERIOD: rd_data = DATA_W'(arr_reg_q);
            A_COUNT:  rd_data = DATA_W'(cnt_q);
            default:  rd_data = '0;
        endcase
    end

    assign cnt_o = cnt_q;
    assign upd_o = upd_q;

    // R8
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_o == $past(wr_data[CNT_W-1:0]));

    // R6
    force_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ug_wr |=> (cnt_o == '0 && upd_o));

    // R7
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && !ctrl_wr && !ug_wr && !cnt_wr) |=> $stable(cnt_o));

    // R9
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && mode_q == MODE_GATED && !trig_lvl && !wr_en) |=> $stable(cnt_o));

endmodule

// File: tb/slv_timer_tb.sv
module slv_timer_tb;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 8;
    localparam int PSC_W  = 4;
    localparam int NT     = 4;

    localparam int NV = 6;
    // prescale, period, counting clocks
    localparam int VEC [NV][3] = '{
        '{0, 9, 25}, '{2, 4, 31}, '{3, 7, 100},
        '{1, 0, 7},  '{0, 255, 300}, '{15, 2, 200}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [2:0]        rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic [NT-1:0]     trig = '0;
    logic              ea = 1'b0, eb = 1'b0;
    logic [CNT_W-1:0]  cnt;
    logic              upd;

    int checks = 0, fails = 0, upd_cnt = 0;
    logic pre = 1'b0;

    slv_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .NUM_TRIG(NT)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .trig_i(trig), .enc_a_i(ea), .enc_b_i(eb),
        .cnt_o(cnt), .upd_o(upd));

    always #5 clk = ~clk;

    always @(negedge clk) if (upd) upd_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = DATA_W'(d);
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        rd_addr = a; #1; d = int'(rd_data);
    endtask

    // counts for exactly k clock edges
    task automatic run_for(input int k);
        wr(3'd0, {30'd0, pre, 1'b1});
        idle(k - 1);
        wr(3'd0, {30'd0, pre, 1'b0});
    endtask

    task automatic restart(input int p, input int a);
        wr(3'd3, p); wr(3'd4, a); wr(3'd2, 1);
        idle(2); upd_cnt = 0;
    endtask

    task automatic qstep(input logic a, input logic b);
        ea = a; eb = b; idle(4);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int v, e;
        idle(3); rst_n = 1'b1; idle(2);

        // R1 reset state
        chk("R1 count", int'(cnt), 0);
        chk("R1 upd", upd_cnt, 0);
        rd(3'd0, v); chk("R1 ctrl", v, 0);
        rd(3'd1, v); chk("R1 mode", v, 0);
        rd(3'd4, v); chk("R1 period", v, 255);

        // R2 R3 table walk
        for (int i = 0; i < NV; i++) begin
            int p, a, k;
            p = VEC[i][0]; a = VEC[i][1]; k = VEC[i][2];
            restart(p, a);
            run_for(k);
            idle(3);
            chk("R2 count", int'(cnt), (k / (p + 1)) % (a + 1));
            chk("R3 updates", upd_cnt, k / ((p + 1) * (a + 1)));
        end

        // R7 freeze
        v = int'(cnt); idle(10);
        chk("R7 frozen", int'(cnt), v);

        // R4 preload on
        pre = 1'b1; wr(3'd0, 2);
        restart(0, 9);
        run_for(5); chk("R4 pre", int'(cnt), 5);
        wr(3'd4, 3);
        run_for(6); idle(2);
        chk("R4 old period", int'(cnt), 1);
        chk("R4 one update", upd_cnt, 1);
        run_for(4); idle(2);
        chk("R4 new period", int'(cnt), 1);
        chk("R4 second update", upd_cnt, 2);

        // R5 preload off
        pre = 1'b0; wr(3'd0, 0);
        restart(0, 9);
        run_for(5);
        wr(3'd4, 3);
        run_for(1); idle(2);
        chk("R5 immediate wrap", int'(cnt), 0);
        chk("R5 update", upd_cnt, 1);

        // R6 forced update restarts prescaler
        restart(3, 20);
        run_for(6); chk("R6 pre", int'(cnt), 1);
        wr(3'd2, 1); idle(1);
        chk("R6 cleared", int'(cnt), 0);
        chk("R6 pulse", upd_cnt, 1);
        rd(3'd2, v); chk("R6 reads zero", v, 0);
        run_for(3); chk("R6 prescaler restarted", int'(cnt), 0);

        // R8 count write
        wr(3'd5, 7); chk("R8 count write", int'(cnt), 7);

        // R9 R11 gated, trigger index 2
        wr(3'd1, (2 << 4) | 5);
        restart(0, 255);
        wr(3'd0, 1);
        idle(6); chk("R9 low gate", int'(cnt), 0);
        trig[1] = 1'b1; idle(8); trig[1] = 1'b0; idle(4);
        chk("R11 unselected gate", int'(cnt), 0);
        trig[2] = 1'b1; idle(9); trig[2] = 1'b0; idle(4);
        chk("R9 gated count", int'(cnt), 9);
        wr(3'd0, 0);

        // R10 R11 triggered
        wr(3'd1, (2 << 4) | 6);
        restart(0, 255);
        trig[0] = 1'b1; idle(6); trig[0] = 1'b0; idle(4);
        chk("R11 unselected start", int'(cnt), 0);
        rd(3'd0, v); chk("R11 run clear", v, 0);
        trig[2] = 1'b1; idle(10);
        chk("R10 started", int'(cnt), 7);
        trig[2] = 1'b0; idle(5);
        chk("R10 keeps running", int'(cnt), 12);
        rd(3'd0, v); chk("R10 run set", v, 1);
        wr(3'd0, 0); v = int'(cnt); idle(5);
        chk("R10 stop", int'(cnt), v);

        // R12 R13 quadrature
        wr(3'd1, 3);
        restart(0, 255);
        wr(3'd0, 1);
        wr(3'd5, 10);
        for (int c = 0; c < 2; c++) begin
            qstep(1, 0); qstep(1, 1); qstep(0, 1); qstep(0, 0);
        end
        chk("R12 forward", int'(cnt), 18);
        qstep(0, 1); qstep(1, 1); qstep(1, 0);
        chk("R12 backward", int'(cnt), 15);
        wr(3'd4, 50); wr(3'd5, 0); idle(1); upd_cnt = 0;
        qstep(0, 0);
        chk("R13 down wrap", int'(cnt), 50);
        chk("R13 down update", upd_cnt, 1);
        qstep(1, 0);
        chk("R13 up wrap", int'(cnt), 0);
        e = 2; chk("R13 up update", upd_cnt, e);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule